// File: doc/BRIEF.md
# FIFO Fill-Level Watermark and Overflow Event Generator

This block watches two byte queues, one carrying outgoing data and one holding incoming data. Each queue holds up to 32 entries. The block turns their fill levels and write activity into raw interrupt conditions. Software picks a trigger level for each queue through a small code. The incoming queue uses a 3-bit code and the outgoing queue uses a 2-bit code. The incoming queue raises its watermark when it has filled to the chosen level or beyond. The outgoing queue raises its watermark when it has drained below its chosen level.

Each watermark event is a single-cycle pulse on the rising edge of its condition. An overflow event pulses when a write is attempted into a full queue. A per-queue clear strobe makes the block treat that queue as empty for that cycle and masks that queue's watermark edge in that cycle. A packed status word reports both fill levels. All outputs are registered, so every output reflects the inputs sampled at the previous rising clock edge. Interrupt enable, latching and test logic sit outside this block.

Top module: `fifo_wmark_irq`

## Requirements
- R1: The incoming watermark condition is `rx_lvl >= threshold`. `rx_sel` selects the threshold: code 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16 and 4 gives 30 entries.
- R2: Incoming codes 5, 6 and 7 behave exactly like code 4 (threshold 30).
- R3: The outgoing watermark condition is `tx_lvl < threshold`. `tx_sel` selects the threshold: code 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16 entries.
- R4: `tx_wm_evt` and `rx_wm_evt` go high for exactly one cycle, in the cycle after the first sampled edge in which the condition is true. They stay low while the condition remains true.
- R5: While `rst_n` is low, all event outputs and `lvl_status` are zero. The condition history resets to false, so a condition that is true at the first edge after reset produces one pulse.
- R6: `tx_push && tx_full` in a sampled cycle gives a one-cycle `tx_ovf_evt` in the next cycle, and the same holds for the incoming queue with `rx_push && rx_full`. A push without full, or full without a push, gives no event. The two queues are independent.
- R7: `lvl_status[5:0]` holds the outgoing level and `lvl_status[21:16]` holds the incoming level, one cycle after sampling. All other bits are zero.
- R8: A clear strobe (`tx_clr` or `rx_clr`) makes that queue's level count as zero for that cycle. The status field reads 0 in the next cycle, and no watermark pulse comes from that cycle for that queue. The history takes the forced level, so a condition that stays true afterwards gives no pulse. The other queue and the overflow logic are not affected.
- R9: A change of trigger code alone that makes the condition true produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_lvl | input | 6 | Outgoing queue fill level |
| rx_lvl | input | 6 | Incoming queue fill level |
| tx_push | input | 1 | Write attempt into outgoing queue |
| rx_push | input | 1 | Write attempt into incoming queue |
| tx_full | input | 1 | Outgoing queue full |
| rx_full | input | 1 | Incoming queue full |
| tx_clr | input | 1 | Outgoing queue clear strobe |
| rx_clr | input | 1 | Incoming queue clear strobe |
| tx_sel | input | 2 | Outgoing trigger-level code |
| rx_sel | input | 3 | Incoming trigger-level code |
| tx_wm_evt | output | 1 | Outgoing watermark pulse |
| rx_wm_evt | output | 1 | Incoming watermark pulse |
| tx_ovf_evt | output | 1 | Outgoing overflow pulse |
| rx_ovf_evt | output | 1 | Incoming overflow pulse |
| lvl_status | output | 32 | Packed fill levels |

## Verification
The interesting collision is a clear strobe that lands in the very cycle in which a watermark edge would otherwise fire. The bench provokes it on the outgoing queue: the forced zero level would make the drain condition rise, and the bench expects no pulse, a zeroed status field and no late pulse in the following cycle. In the same kind of cycle, an overflow on the incoming queue is driven together with that queue's clear strobe and a level crossing. The bench expects the overflow pulse to survive while the watermark pulse is masked.

// File: rtl/fwi_pkg.sv
package fwi_pkg;

  typedef enum logic [0:0] {
    WM_AT_OR_ABOVE = 1'b0,
    WM_BELOW       = 1'b1
  } wm_dir_e;

  typedef struct packed {
    logic tx;
    logic rx;
  } evt_pair_t;

endpackage

// File: rtl/fwi_thresh_dec.sv
module fwi_thresh_dec #(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned NUM_POW = 4,
  parameter int unsigned CAP_TH  = 30
) (
  input  logic [CODE_W-1:0] code,
  output logic [LVL_W-1:0]  thresh
);

  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

  logic [LVL_W-1:0] th_d;

  always_comb begin
    if (code == '0) begin
      th_d = LVL_W'(1);
    end else if (CODE_MAX >= NUM_POW && 32'(code) >= NUM_POW) begin
      th_d = LVL_W'(CAP_TH);
    end else begin
      th_d = LVL_W'(1) << (32'(code) + 32'd1);
    end
  end

  assign thresh = th_d;

  // R1 R3: a decoded threshold is never zero
  always_comb begin
    a_th_nonzero_r1: assert (thresh != '0);
  end

endmodule

// File: rtl/fwi_wmark_chan.sv
module fwi_wmark_chan
  import fwi_pkg::*;
#(
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned NUM_POW = 4,
  parameter int unsigned CAP_TH  = 30,
  parameter wm_dir_e     DIR     = WM_AT_OR_ABOVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic [LVL_W-1:0]  eff_lvl,
  output logic              evt
);

  logic [LVL_W-1:0] thresh;
  logic             cond;
  logic             cond_q, cond_d;
  logic             evt_q, evt_d;

  fwi_thresh_dec #(
    .CODE_W (CODE_W),
    .LVL_W  (LVL_W),
    .NUM_POW(NUM_POW),
    .CAP_TH (CAP_TH)
  ) u_dec (
    .code  (code),
    .thresh(thresh)
  );

  assign eff_lvl = clr ? '0 : lvl;

  generate
    if (DIR == WM_AT_OR_ABOVE) begin : g_fill
      assign cond = (eff_lvl >= thresh);
    end else begin : g_drain
      assign cond = (eff_lvl < thresh);
    end
  endgenerate

  always_comb begin
    cond_d = cond;
    evt_d  = cond & ~cond_q & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cond_q <= cond_d;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;

  // R4: a pulse never lasts two cycles
  p_wm_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  // R8: a clear cycle never yields a pulse
  p_clr_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !evt);

endmodule

// File: rtl/fwi_ovf_det.sv
module fwi_ovf_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] push,
  input  logic [N-1:0] full,
  output logic [N-1:0] ovf
);

  logic [N-1:0] ovf_q, ovf_d;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_comb begin
      ovf_d[i] = push[i] & full[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_q[i] <= 1'b0;
      end else begin
        ovf_q[i] <= ovf_d[i];
      end
    end

    // R6: an attempted write into a full queue is reported
    p_ovf_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push[i] && full[i]) |=> ovf[i]);

    // R6: no report without both push and full
    p_ovf_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(push[i] && full[i]) |=> !ovf[i]);
  end

  assign ovf = ovf_q;

endmodule

// File: rtl/fwi_status_pack.sv
module fwi_status_pack #(
  parameter int unsigned LVL_W  = 6,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned RX_OFS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  tx_lvl,
  input  logic [LVL_W-1:0]  rx_lvl,
  output logic [WORD_W-1:0] word
);

  localparam logic [WORD_W-1:0] FIELD_MASK =
    (WORD_W'((1 << LVL_W) - 1)) | (WORD_W'((1 << LVL_W) - 1) << RX_OFS);

  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = '0;
    word_d[LVL_W-1:0]             = tx_lvl;
    word_d[RX_OFS +: LVL_W]       = rx_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

  // R7: padding bits stay zero
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word & ~FIELD_MASK) == '0);

endmodule

// File: rtl/fifo_wmark_irq.sv
module fifo_wmark_irq
  import fwi_pkg::*;
#(
  parameter int unsigned LVL_W     = 6,
  parameter int unsigned RX_CODE_W = 3,
  parameter int unsigned TX_CODE_W = 2,
  parameter int unsigned NUM_POW   = 4,
  parameter int unsigned RX_CAP_TH = 30,
  parameter int unsigned TX_CAP_TH = 16,
  parameter int unsigned STAT_W    = 32,
  parameter int unsigned RX_OFS    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_W-1:0]     tx_lvl,
  input  logic [LVL_W-1:0]     rx_lvl,
  input  logic                 tx_push,
  input  logic                 rx_push,
  input  logic                 tx_full,
  input  logic                 rx_full,
  input  logic                 tx_clr,
  input  logic                 rx_clr,
  input  logic [TX_CODE_W-1:0] tx_sel,
  input  logic [RX_CODE_W-1:0] rx_sel,
  output logic                 tx_wm_evt,
  output logic                 rx_wm_evt,
  output logic                 tx_ovf_evt,
  output logic                 rx_ovf_evt,
  output logic [STAT_W-1:0]    lvl_status
);

  localparam int unsigned NCH = 2;

  logic [LVL_W-1:0] tx_eff, rx_eff;
  evt_pair_t        push_v, full_v, ovf_v;

  fwi_wmark_chan #(
    .LVL_W  (LVL_W),
    .CODE_W (TX_CODE_W),
    .NUM_POW(NUM_POW),
    .CAP_TH (TX_CAP_TH),
    .DIR    (WM_BELOW)
  ) u_tx_wm (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (tx_lvl),
    .clr    (tx_clr),
    .code   (tx_sel),
    .eff_lvl(tx_eff),
    .evt    (tx_wm_evt)
  );

  fwi_wmark_chan #(
    .LVL_W  (LVL_W),
    .CODE_W (RX_CODE_W),
    .NUM_POW(NUM_POW),
    .CAP_TH (RX_CAP_TH),
    .DIR    (WM_AT_OR_ABOVE)
  ) u_rx_wm (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (rx_lvl),
    .clr    (rx_clr),
    .code   (rx_sel),
    .eff_lvl(rx_eff),
    .evt    (rx_wm_evt)
  );

  assign push_v = '{tx: tx_push, rx: rx_push};
  assign full_v = '{tx: tx_full, rx: rx_full};

  fwi_ovf_det #(
    .N(NCH)
  ) u_ovf (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_v),
    .full (full_v),
    .ovf  (ovf_v)
  );

  assign tx_ovf_evt = ovf_v.tx;
  assign rx_ovf_evt = ovf_v.rx;

  fwi_status_pack #(
    .LVL_W (LVL_W),
    .WORD_W(STAT_W),
    .RX_OFS(RX_OFS)
  ) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_lvl(tx_eff),
    .rx_lvl(rx_eff),
    .word  (lvl_status)
  );

  // R8: a cleared queue reads as empty in the next status word
  p_tx_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (lvl_status[LVL_W-1:0] == '0));

  p_rx_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (lvl_status[RX_OFS +: LVL_W] == '0));

  // R5: outputs are quiet while reset is applied
  always_comb begin
    if (!rst_n) begin
      a_rst_quiet_r5: assert (!tx_wm_evt && !rx_wm_evt && !tx_ovf_evt
                              && !rx_ovf_evt && lvl_status == '0);
    end
  end

endmodule

// File: tb/fifo_wmark_irq_tb.sv
module fifo_wmark_irq_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] tx_lvl, rx_lvl;
  logic       tx_push, rx_push, tx_full, rx_full, tx_clr, rx_clr;
  logic [1:0] tx_sel;
  logic [2:0] rx_sel;
  logic       tx_wm_evt, rx_wm_evt, tx_ovf_evt, rx_ovf_evt;
  logic [31:0] lvl_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_wmark_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .tx_push(tx_push), .rx_push(rx_push),
    .tx_full(tx_full), .rx_full(rx_full),
    .tx_clr(tx_clr), .rx_clr(rx_clr),
    .tx_sel(tx_sel), .rx_sel(rx_sel),
    .tx_wm_evt(tx_wm_evt), .rx_wm_evt(rx_wm_evt),
    .tx_ovf_evt(tx_ovf_evt), .rx_ovf_evt(rx_ovf_evt),
    .lvl_status(lvl_status)
  );

  function automatic int rx_th(int c);
    case (c)
      0: return 1;
      1: return 4;
      2: return 8;
      3: return 16;
      default: return 30;
    endcase
  endfunction

  function automatic int tx_th(int c);
    case (c)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // drive at negedge, then sample just after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    @(negedge clk);
    tx_lvl = 6'd5; rx_lvl = 6'd0; tx_push = 0; rx_push = 0;
    tx_full = 0; rx_full = 0; tx_clr = 0; rx_clr = 0;
    tx_sel = 2'd0; rx_sel = 3'd0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    tx_lvl = 6'd0; rx_lvl = 6'd0; tx_push = 1; rx_push = 1;
    tx_full = 1; rx_full = 1; tx_clr = 0; rx_clr = 0;
    tx_sel = 2'd0; rx_sel = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    chk({27'd0, tx_wm_evt, rx_wm_evt, tx_ovf_evt, rx_ovf_evt}, 0, "R5 events in reset");
    chk(lvl_status, 0, "R5 status in reset");
    @(negedge clk);
    tx_push = 0; rx_push = 0; tx_full = 0; rx_full = 0;
    rst_n = 1;
    step();
    chk(tx_wm_evt, 1, "R5 first pulse after reset");
    step();
    chk(tx_wm_evt, 0, "R5 pulse ends");
  endtask

  task automatic t_rx_codes();
    for (int c = 0; c < 8; c++) begin
      int th = rx_th(c);
      string rq = (c > 4) ? "R2" : "R1";
      @(negedge clk); rx_sel = 3'(c); rx_lvl = 0;
      step(); chk(rx_wm_evt, 0, rq);
      @(negedge clk); rx_lvl = 6'(th - 1);
      step(); chk(rx_wm_evt, 0, {rq, " below threshold"});
      @(negedge clk); rx_lvl = 6'(th);
      step(); chk(rx_wm_evt, 1, {rq, " at threshold"});
      @(negedge clk); rx_lvl = 6'(th + 1);
      step(); chk(rx_wm_evt, 0, "R4 no repeat while true");
      @(negedge clk); rx_lvl = 0;
      step();
    end
  endtask

  task automatic t_tx_codes();
    for (int c = 0; c < 4; c++) begin
      int th = tx_th(c);
      @(negedge clk); tx_sel = 2'(c); tx_lvl = 6'(th);
      step(); step(); chk(tx_wm_evt, 0, "R3 at threshold no pulse");
      @(negedge clk); tx_lvl = 6'(th - 1);
      step(); chk(tx_wm_evt, 1, "R3 below threshold");
      step(); chk(tx_wm_evt, 0, "R4 single cycle");
      @(negedge clk); tx_lvl = 6'(th);
      step(); chk(tx_wm_evt, 0, "R3 falling no pulse");
    end
  endtask

  task automatic t_overflow();
    @(negedge clk); tx_push = 1; tx_full = 1;
    step(); chk({tx_ovf_evt, rx_ovf_evt}, 2'b10, "R6 tx overflow");
    @(negedge clk); tx_push = 1; tx_full = 0;
    step(); chk({tx_ovf_evt, rx_ovf_evt}, 2'b00, "R6 push without full");
    @(negedge clk); tx_push = 0; tx_full = 1; rx_full = 1;
    step(); chk({tx_ovf_evt, rx_ovf_evt}, 2'b00, "R6 full without push");
    @(negedge clk); tx_push = 1; rx_push = 1;
    step(); chk({tx_ovf_evt, rx_ovf_evt}, 2'b11, "R6 both overflow");
    @(negedge clk); tx_push = 0; rx_push = 0; tx_full = 0; rx_full = 0;
    step(); chk({tx_ovf_evt, rx_ovf_evt}, 2'b00, "R6 pulse ends");
  endtask

  task automatic t_status();
    @(negedge clk); tx_lvl = 6'd32; rx_lvl = 6'd17; rx_sel = 3'd4;
    step(); chk(lvl_status, 32'h0011_0020, "R7 status packing");
    @(negedge clk); tx_lvl = 6'd9; rx_lvl = 6'd31;
    step(); chk(lvl_status, 32'h001F_0009, "R7 status update");
    step(); // settle history: rx 31>=30 pulsed
  endtask

  task automatic t_clear();
    @(negedge clk); rx_sel = 3'd0; rx_lvl = 6'd3; tx_sel = 2'd3; tx_lvl = 6'd20;
    step(); step();
    // tx clear would create a drain edge: masked
    @(negedge clk); tx_clr = 1;
    step();
    chk(tx_wm_evt, 0, "R8 tx edge masked by clear");
    chk(lvl_status, 32'h0003_0000, "R8 tx field forced zero");
    @(negedge clk); tx_clr = 0; tx_lvl = 6'd0;
    step(); chk(tx_wm_evt, 0, "R8 no late pulse");
    // rx clear with overflow and level crossing in same cycle
    @(negedge clk); rx_sel = 3'd1; rx_lvl = 6'd0; tx_lvl = 6'd20;
    step();
    @(negedge clk); rx_lvl = 6'd10; rx_clr = 1; rx_push = 1; rx_full = 1;
    step();
    chk(rx_wm_evt, 0, "R8 rx edge masked by clear");
    chk(rx_ovf_evt, 1, "R8 overflow survives clear");
    chk(lvl_status[21:16], 0, "R8 rx field forced zero");
    @(negedge clk); rx_clr = 0; rx_push = 0; rx_full = 0;
    step(); chk(rx_wm_evt, 1, "R8 edge after clear released");
    chk(lvl_status[21:16], 10, "R7 rx field restored");
  endtask

  task automatic t_code_change();
    @(negedge clk); rx_sel = 3'd4; rx_lvl = 6'd8;
    step(); step(); chk(rx_wm_evt, 0, "R9 below 30");
    @(negedge clk); rx_sel = 3'd2;
    step(); chk(rx_wm_evt, 1, "R9 code change raises pulse");
    @(negedge clk); tx_sel = 2'd0; tx_lvl = 6'd2;
    step(); step();
    @(negedge clk); tx_sel = 2'd2;
    step(); chk(tx_wm_evt, 1, "R9 tx code change raises pulse");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    quiet();
    step();
    t_rx_codes();
    quiet(); step();
    t_tx_codes();
    quiet(); step();
    t_overflow();
    t_status();
    quiet(); step();
    t_clear();
    quiet(); step();
    t_code_change();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule